// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus. Software programs a reload value in clock cycles and starts the timer by writing any enable code other than a fixed stop key. Software then keeps the system alive by writing to the status register before the down-counter reaches zero. A write to the status register is a "kick", and its data is ignored.

If the counter reaches zero while the timer runs, a sticky expired flag sets. One of three event outputs then asserts, chosen by a two-bit action field: system reset, non-maskable interrupt, general-purpose interrupt, or no event. The event stays asserted until software stops the timer and clears the flag. The timer can only be stopped by writing the 8-bit stop key 0xAD into the enable field, so a stray write of zeros cannot disable it.

The register map is address 0 = control, 1 = reload, 2 = status. Reads are combinational from `bus_addr`. A write takes effect at the rising clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control reads 0x0000_0AD6 (enable field 0xAD, action 11, expired 0), reload reads 0xFFFF_FFFF, status reads 0xFFFF_FFFF, and all three event outputs are low.
- R2: The timer runs exactly when control bits 11:4 differ from 0xAD. The edge that stores the key still counts, and from the next edge on the status value holds.
- R3: A control write that moves the enable field from the key to any other value loads status from reload at that edge. Status then drops by one per clock. A control write while already running does not reload.
- R4: Any write to status (address 2) loads the counter from reload at that edge, whatever the data, whether the timer runs or not.
- R5: When status is 0 at a clock edge while running, control bit 15 (expired) sets at that edge, and status stays at 0 until a reload.
- R6: Control bits 2:1 select the event: 00 drives `evt_reset`, 01 `evt_nmi`, 10 `evt_gpi`, 11 none. The selected output is high exactly while the expired flag is set, and at most one output is ever high.
- R7: Writing 1 to control bit 15 clears the expired flag, and writing 0 leaves it. Stopping the timer with the key does not clear it.
- R8: Reload (address 1) reads back the value written. Writing it does not change status, and a new value written while stopped is used at the next start.
- R9: If an expiry and a clear write fall on the same edge, the flag stays set.
- R10: Writes to address 3 change no register, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, sampled with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| evt_reset | output | 1 | Expiry event: system reset |
| evt_nmi | output | 1 | Expiry event: non-maskable interrupt |
| evt_gpi | output | 1 | Expiry event: general-purpose interrupt |

## Verification
The assertions assume at most one write per clock, and that the reload value is stable across the edge that follows a load, so `$past(reload)` names the value loaded. The bench keeps each write to exactly one clock and never writes reload and status in the same cycle. The sweep runs every action code against several reload values, including 0 and 1, and several non-key enable codes. Each wait is counted from the edge of the starting write, so the cycle of expiry follows from the reload value alone.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int CTRL_W   = 16;
    localparam int EXP_BIT  = 15;
    localparam int EN_LSB   = 4;
    localparam int EN_W     = 8;
    localparam int ACT_LSB  = 1;
    localparam int ACT_W    = 2;
    localparam int ADDR_W   = 2;
    localparam int N_EVT    = 3;

    localparam logic [EN_W-1:0]   STOP_KEY = 8'hAD;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    typedef enum logic [ACT_W-1:0] {
        ACT_RESET = 2'b00,
        ACT_NMI   = 2'b01,
        ACT_GPI   = 2'b10,
        ACT_NONE  = 2'b11
    } wdg_act_e;

    typedef struct packed {
        logic            expired;
        logic [EN_W-1:0] en;
        wdg_act_e        act;
    } wdg_ctrl_t;

    function automatic logic is_running(input logic [EN_W-1:0] en);
        return en != STOP_KEY;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_word(input wdg_ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[EXP_BIT]                 = c.expired;
        w[EN_LSB +: EN_W]          = c.en;
        w[ACT_LSB +: ACT_W]        = c.act;
        return w;
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import keyed_wdog_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctrl,
    input  logic            wr_clr,
    input  logic [EN_W-1:0] wr_en,
    input  wdg_act_e        wr_act,
    input  logic            at_zero,
    output wdg_ctrl_t       ctrl,
    output logic            run,
    output logic            start
);

    logic expire_now;

    assign run        = is_running(ctrl.en);
    assign start      = wr_ctrl && !run && is_running(wr_en);
    assign expire_now = run && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.expired <= 1'b0;
            ctrl.en      <= STOP_KEY;
            ctrl.act     <= ACT_NONE;
        end else begin
            if (wr_ctrl) begin
                ctrl.en  <= wr_en;
                ctrl.act <= wr_act;
            end
            if (expire_now)
                ctrl.expired <= 1'b1;
            else if (wr_ctrl && wr_clr)
                ctrl.expired <= 1'b0;
        end
    end

    AST_EXP_SET: assert property (@(posedge clk) disable iff (rst)
        (run && at_zero) |=> ctrl.expired) else $error("expiry missed"); // R5

    AST_EXP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.expired && !(wr_ctrl && wr_clr)) |=> ctrl.expired) else $error("flag lost"); // R7

    AST_CLR_WINS_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.expired && wr_ctrl && wr_clr && !(run && at_zero)) |=> !ctrl.expired) else $error("clear lost"); // R7

endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '1;
        else if (load)
            cnt <= reload;
        else if (run && !at_zero)
            cnt <= cnt - 1'b1;
    end

    AST_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(reload))) else $error("load wrong"); // R4

    AST_DEC: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !at_zero) |=> (cnt == $past(cnt) - 1'b1)) else $error("no decrement"); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt)) else $error("moved while stopped"); // R2

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !load) |=> (cnt == '0)) else $error("left zero"); // R5

endmodule

// File: rtl/wdg_evt_sel.sv
module wdg_evt_sel
    import keyed_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wdg_ctrl_t        ctrl,
    output logic [N_EVT-1:0] evt
);

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        assign evt[g] = ctrl.expired && (ctrl.act == wdg_act_e'(ACT_W'(g)));
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt)) else $error("several events"); // R6

    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctrl.act == ACT_NONE) |-> (evt == '0)) else $error("event on none"); // R6

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              evt_reset,
    output logic              evt_nmi,
    output logic              evt_gpi
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    logic             wr_any, wr_ctrl, wr_reload, wr_status;
    logic [CNT_W-1:0] reload, cnt;
    logic             run, start, at_zero;
    wdg_ctrl_t        ctrl;
    logic [N_EVT-1:0] evt;

    assign wr_any    = bus_sel && bus_wr;
    assign wr_ctrl   = wr_any && (bus_addr == A_CTRL);
    assign wr_reload = wr_any && (bus_addr == A_RELOAD);
    assign wr_status = wr_any && (bus_addr == A_STATUS);

    always_ff @(posedge clk) begin
        if (rst)
            reload <= RELOAD_RST;
        else if (wr_reload)
            reload <= bus_wdata[CNT_W-1:0];
    end

    wdg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_clr  (bus_wdata[EXP_BIT]),
        .wr_en   (bus_wdata[EN_LSB +: EN_W]),
        .wr_act  (wdg_act_e'(bus_wdata[ACT_LSB +: ACT_W])),
        .at_zero (at_zero),
        .ctrl    (ctrl),
        .run     (run),
        .start   (start)
    );

    wdg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .load    (wr_status || start),
        .reload  (reload),
        .cnt     (cnt),
        .at_zero (at_zero)
    );

    wdg_evt_sel u_evt (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .evt  (evt)
    );

    assign evt_reset = evt[ACT_RESET];
    assign evt_nmi   = evt[ACT_NMI];
    assign evt_gpi   = evt[ACT_GPI];

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = DATA_W'(ctrl_word(ctrl));
            A_RELOAD: bus_rdata = DATA_W'(reload);
            A_STATUS: bus_rdata = DATA_W'(cnt);
            default:  bus_rdata = '0;
        endcase
    end

    AST_RELOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_reload) |=> $stable(reload)) else $error("reload changed"); // R10

endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEY = 8'hAD;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        evt_reset, evt_nmi, evt_gpi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_reset(evt_reset), .evt_nmi(evt_nmi), .evt_gpi(evt_gpi)
    );

    function automatic logic [31:0] cw(input logic ex, input logic [7:0] en, input logic [1:0] act);
        return {16'h0, ex, 3'b000, en, 1'b0, act, 1'b0};
    endfunction

    function automatic logic [2:0] evt_exp(input logic ex, input logic [1:0] act);
        if (!ex || act == 2'b11) return 3'b000;
        return 3'b001 << act;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic chk_evt(input string req, input logic [2:0] exp);
        chk(req, {29'h0, evt_gpi, evt_nmi, evt_reset}, {29'h0, exp});
    endtask

    function automatic int nval(input int i);
        case (i) 0: return 0; 1: return 1; 2: return 2; 3: return 5; default: return 9; endcase
    endfunction

    function automatic logic [7:0] enval(input int i);
        case (i) 0: return 8'h00; 1: return 8'hAC; 2: return 8'hAE; 3: return 8'hFF; default: return 8'h5A; endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) tick();
        rst = 1'b0;

        // R1 reset state
        chk_rd("R1 ctrl", 2'd0, 32'h0000_0AD6);
        chk_rd("R1 reload", 2'd1, 32'hFFFF_FFFF);
        chk_rd("R1 status", 2'd2, 32'hFFFF_FFFF);
        chk_evt("R1 events", 3'b000);
        repeat (3) tick();
        chk_rd("R2 stopped after reset", 2'd2, 32'hFFFF_FFFF);

        // Sweep: every action, several reloads and enable codes
        for (int a = 0; a < 4; a++) begin
            for (int ni = 0; ni < 5; ni++) begin
                int n;
                logic [7:0] en;
                n  = nval(ni);
                en = enval((a + ni) % 5);
                wr(2'd0, cw(1'b1, KEY, 2'(a)));
                wr(2'd1, 32'(n));
                chk_rd("R8 reload readback", 2'd1, 32'(n));
                wr(2'd0, cw(1'b0, en, 2'(a)));
                for (int k = 0; k <= n; k++) begin
                    chk_rd("R3 countdown", 2'd2, 32'(n - k));
                    chk_rd("R5 not yet expired", 2'd0, cw(1'b0, en, 2'(a)));
                    chk_evt("R6 quiet before expiry", 3'b000);
                    tick();
                end
                chk_rd("R5 expired flag", 2'd0, cw(1'b1, en, 2'(a)));
                chk_rd("R5 status at zero", 2'd2, 32'h0);
                chk_evt("R6 selected event", evt_exp(1'b1, 2'(a)));
                repeat (2) tick();
                chk_rd("R5 zero holds", 2'd2, 32'h0);
                wr(2'd0, cw(1'b0, KEY, 2'(a)));
                chk_rd("R7 stop keeps flag", 2'd0, cw(1'b1, KEY, 2'(a)));
                wr(2'd0, cw(1'b0, KEY, 2'(a)));
                chk_rd("R7 write 0 keeps flag", 2'd0, cw(1'b1, KEY, 2'(a)));
                chk_evt("R7 event held", evt_exp(1'b1, 2'(a)));
                wr(2'd0, cw(1'b1, KEY, 2'(a)));
                chk_rd("R7 write 1 clears", 2'd0, cw(1'b0, KEY, 2'(a)));
                chk_evt("R7 event dropped", 3'b000);
            end
        end

        // R3: write while running does not reload
        wr(2'd1, 32'd30);
        wr(2'd0, cw(1'b0, 8'h00, 2'b11));
        repeat (4) tick();
        chk_rd("R3 running count", 2'd2, 32'd26);
        wr(2'd0, cw(1'b0, 8'h11, 2'b11));
        chk_rd("R3 no reload when running", 2'd2, 32'd25);

        // R2: key stops counting after its edge
        repeat (2) tick();
        wr(2'd0, cw(1'b0, KEY, 2'b11));
        chk_rd("R2 key edge counts", 2'd2, 32'd22);
        repeat (5) tick();
        chk_rd("R2 held after key", 2'd2, 32'd22);

        // R4: kick while stopped
        wr(2'd2, 32'hDEAD_BEEF);
        chk_rd("R4 kick stopped", 2'd2, 32'd30);
        repeat (3) tick();
        chk_rd("R4 stays stopped", 2'd2, 32'd30);

        // R8: new reload while stopped used at next start
        wr(2'd1, 32'd12);
        chk_rd("R8 status untouched", 2'd2, 32'd30);
        wr(2'd0, cw(1'b0, 8'h00, 2'b11));
        chk_rd("R8 start uses new reload", 2'd2, 32'd12);
        repeat (2) tick();
        chk_rd("R8 counting", 2'd2, 32'd10);

        // R4: kick while running, data zero
        wr(2'd2, 32'h0);
        chk_rd("R4 kick running", 2'd2, 32'd12);
        tick();
        chk_rd("R4 counts after kick", 2'd2, 32'd11);

        // R9: clear on an expiring edge loses
        wr(2'd1, 32'd1);
        wr(2'd2, 32'h5555_0000);
        chk_rd("R4 kick to 1", 2'd2, 32'd1);
        tick();
        tick();
        chk_rd("R5 expired with none", 2'd0, cw(1'b1, 8'h00, 2'b11));
        chk_evt("R6 none gives no event", 3'b000);
        wr(2'd0, cw(1'b1, 8'h00, 2'b01));
        chk_rd("R9 set beats clear", 2'd0, cw(1'b1, 8'h00, 2'b01));
        chk_evt("R6 live action change", 3'b010);
        wr(2'd0, cw(1'b0, KEY, 2'b01));
        wr(2'd0, cw(1'b1, KEY, 2'b01));
        chk_rd("R7 cleared after stop", 2'd0, cw(1'b0, KEY, 2'b01));

        // R10: unmapped address
        wr(2'd3, 32'hFFFF_FFFF);
        chk_rd("R10 ctrl unchanged", 2'd0, cw(1'b0, KEY, 2'b01));
        chk_rd("R10 reload unchanged", 2'd1, 32'd1);
        chk_rd("R10 status unchanged", 2'd2, 32'd0);
        chk_rd("R10 read zero", 2'd3, 32'd0);
        chk_evt("R10 events quiet", 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule